// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a large set of level-sensitive interrupt lines into groups of eight and gives each group a single output line toward a downstream interrupt controller. A group's line is raised when at least one of its sources is both active and enabled. The per-source enable bits live in the block and are changed by software through a 32-bit register port. The same port reads back the raw levels, the enabled levels and a two-word summary of every group's output line.

Registers are organised in 16-byte quads. Each quad serves four neighbouring groups, one byte lane per group. Inside a quad, one word sets enable bits and another clears them, so a single write never disturbs bits it does not name. A build-time mode turns the block into the smaller external variant, in which only the lower groups listen to their inputs.

Access handling is a three-state machine: `ACC_IDLE` (no response), `ACC_RDATA` (read data is presented) and `ACC_WERR` (an illegal write was dropped). From any state a legal write goes to `ACC_IDLE`, an illegal write goes to `ACC_WERR`, a read without a write goes to `ACC_RDATA`, and no access goes to `ACC_IDLE`.

Top module: `grp_irq_combiner`

## Requirements
- R1: Input line n belongs to group n/8 as source bit n mod 8. Its pending bit equals the input level captured at each rising clock edge.
- R2: Output line g is registered. It is high exactly when the previous cycle's (enable AND pending) for group g was nonzero, so it follows a pending or enable change by one clock.
- R3: Address bits [9:4] give quad q, which covers groups 4q to 4q+3. Byte lane k (bits 8k+7:8k) belongs to group 4q+k. A write to quad offset 0x0 ORs each lane into that group's enable bits.
- R4: A write to quad offset 0x4 clears the enable bits wherever the lane holds a 1. It leaves every other enable bit unchanged.
- R5: Reading quad offset 0x8 returns the four raw pending bytes. Reading offset 0xC returns the four (enable AND pending) bytes.
- R6: Reading 0x400 returns the output lines of groups 0 to 31, with group g at bit g. Reading 0x404 returns groups 32 to 63, with group g at bit g-32.
- R7: Reading quad offset 0x0 or 0x4 returns the word last written there. Before any write, the words at 0xC0, 0xC4, 0xD0 and 0xD4 read 0x01010101 and all others read 0.
- R8: Writes to offset 0x8, to offset 0xC, to the summary area (0x400 and above) or to 0x100–0x3FF change nothing. Each such write raises bus_err for exactly the cycle after it. Legal writes leave bus_err low. Reads of 0x100–0x3FF return 0.
- R9: After reset, all enable bits, pending bits and output lines are zero, and bus_rvalid and bus_err are low.
- R10: With EXTERNAL set, groups at or above EXT_GROUPS ignore their inputs. Their pending bits and output lines stay zero.
- R11: A read sampled at a clock edge gives bus_rvalid and bus_rdata for the next cycle only. When bus_wr and bus_rd are high together, the write is performed and no read response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| irq_in | input | 512 | Level-sensitive interrupt sources |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response present |
| bus_err | output | 1 | One-cycle pulse after a dropped write |
| grp_irq | output | 64 | Per-group interrupt outputs |

## Verification
A wrong enable bit shows up on the group's output line two clocks after the source rises, and it also shows up in the quad's masked read and in the summary word. A wrong pending bit shows up in the raw read one clock after the input changes. A wrong lane or quad decode shows up as a neighbouring group's output moving, or not moving, after a write. A wrong stored word only shows on a read of that offset, so each written offset is read back.

// File: rtl/combiner_pkg.sv
package combiner_pkg;

    localparam int GRP_W     = 8;
    localparam int LANES     = 4;
    localparam int WORD_W    = GRP_W * LANES;
    localparam int SUM_WORDS = 2;

    typedef enum logic [1:0] {
        SLOT_SET_EN = 2'd0,
        SLOT_CLR_EN = 2'd1,
        SLOT_RAW    = 2'd2,
        SLOT_MASKED = 2'd3
    } quad_slot_e;

    typedef enum logic [1:0] {
        REGION_QUAD    = 2'd0,
        REGION_HOLE    = 2'd1,
        REGION_SUMMARY = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_RDATA = 2'd1,
        ACC_WERR  = 2'd2
    } acc_state_e;

    // Reset content of a stored enable word, keyed by its byte offset.
    function automatic logic [WORD_W-1:0] enable_word_reset(input int byte_off);
        logic [WORD_W-1:0] v;
        v = '0;
        if (byte_off == 'hC0 || byte_off == 'hC4 || byte_off == 'hD0 || byte_off == 'hD4)
            v = 32'h0101_0101;
        return v;
    endfunction

endpackage

// File: rtl/combiner_decode.sv
module combiner_decode
    import combiner_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int NUM_QUADS    = 16,
    parameter int SUMMARY_BASE = 'h400
) (
    input  logic [ADDR_W-1:0]            addr,
    output region_e                      region,
    output quad_slot_e                   slot,
    output logic [$clog2(NUM_QUADS)-1:0] quad,
    output logic                         sum_word
);
    localparam int SUM_BIT = $clog2(SUMMARY_BASE);
    localparam int QSEL_W  = $clog2(NUM_QUADS);

    logic [5:0] quad_field;

    always_comb begin
        quad_field = addr[9:4];
        slot       = quad_slot_e'(addr[3:2]);
        quad       = quad_field[QSEL_W-1:0];
        sum_word   = addr[2];
        if (addr[SUM_BIT])
            region = REGION_SUMMARY;
        else if (int'(quad_field) < NUM_QUADS)
            region = REGION_QUAD;
        else
            region = REGION_HOLE;
    end
endmodule

// File: rtl/combiner_group.sv
module combiner_group
    import combiner_pkg::*;
#(
    parameter bit ACCEPT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] src,
    input  logic             set_hit,
    input  logic             clr_hit,
    input  logic [GRP_W-1:0] wbyte,
    output logic [GRP_W-1:0] pend_o,
    output logic [GRP_W-1:0] mask_o,
    output logic             irq_o
);
    logic [GRP_W-1:0] mask_q;
    logic [GRP_W-1:0] pend_q;
    logic             irq_q;

    generate
        if (ACCEPT) begin : g_live
            always_ff @(posedge clk) begin
                if (!rst_n) pend_q <= '0;
                else        pend_q <= src;
            end
        end else begin : g_dead
            always_ff @(posedge clk) begin
                pend_q <= '0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (set_hit) begin
            mask_q <= mask_q | wbyte;
        end else if (clr_hit) begin
            mask_q <= mask_q & ~wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(mask_q & pend_q);
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/combiner_enstore.sv
module combiner_enstore
    import combiner_pkg::*;
#(
    parameter int NUM_QUADS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [$clog2(NUM_QUADS)-1:0] wq,
    input  logic                         wsel,
    input  logic [WORD_W-1:0]            wdata,
    input  logic [$clog2(NUM_QUADS)-1:0] rq,
    input  logic                         rsel,
    output logic [WORD_W-1:0]            rdata
);
    localparam int DEPTH = NUM_QUADS * 2;
    localparam int IDX_W = $clog2(DEPTH);

    logic [WORD_W-1:0] words [DEPTH];
    logic [IDX_W-1:0]  widx;
    logic [IDX_W-1:0]  ridx;

    assign widx = {wq, wsel};
    assign ridx = {rq, rsel};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                words[i] <= enable_word_reset((i / 2) * 16 + (i % 2) * 4);
        end else if (we) begin
            words[widx] <= wdata;
        end
    end

    assign rdata = words[ridx];
endmodule

// File: rtl/grp_irq_combiner.sv
module grp_irq_combiner
    import combiner_pkg::*;
#(
    parameter int NUM_GROUPS = 64,
    parameter bit EXTERNAL   = 1'b0,
    parameter int EXT_GROUPS = 16,
    parameter int ADDR_W     = 11
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*GRP_W-1:0] irq_in,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [WORD_W-1:0]           bus_wdata,
    output logic [WORD_W-1:0]           bus_rdata,
    output logic                        bus_rvalid,
    output logic                        bus_err,
    output logic [NUM_GROUPS-1:0]       grp_irq
);
    localparam int NUM_SRC   = NUM_GROUPS * GRP_W;
    localparam int NUM_QUADS = NUM_GROUPS / LANES;
    localparam int QSEL_W    = $clog2(NUM_QUADS);
    localparam int SUM_W     = SUM_WORDS * WORD_W;

    region_e           region;
    quad_slot_e        slot;
    logic [QSEL_W-1:0] quad;
    logic              sum_word;
    logic              wr_legal;
    logic              set_wr;
    logic              clr_wr;
    logic [NUM_SRC-1:0] pend_flat;
    logic [NUM_SRC-1:0] mask_flat;
    logic [WORD_W-1:0] raw_q [NUM_QUADS];
    logic [WORD_W-1:0] msk_q [NUM_QUADS];
    logic [WORD_W-1:0] store_word;
    logic [SUM_W-1:0]  irq_pad;
    logic [WORD_W-1:0] rd_word;
    acc_state_e        acc_q;
    acc_state_e        acc_d;
    logic [WORD_W-1:0] rdata_q;

    combiner_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_QUADS (NUM_QUADS)
    ) u_decode (
        .addr     (bus_addr),
        .region   (region),
        .slot     (slot),
        .quad     (quad),
        .sum_word (sum_word)
    );

    always_comb begin
        wr_legal = bus_wr && (region == REGION_QUAD) &&
                   (slot == SLOT_SET_EN || slot == SLOT_CLR_EN);
        set_wr   = wr_legal && (slot == SLOT_SET_EN);
        clr_wr   = wr_legal && (slot == SLOT_CLR_EN);
    end

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            localparam int QIDX = g / LANES;
            localparam int LANE = g % LANES;
            localparam bit ACC  = !EXTERNAL || (g < EXT_GROUPS);
            logic hit_q;
            assign hit_q = (quad == QSEL_W'(QIDX));
            combiner_group #(.ACCEPT(ACC)) u_grp (
                .clk     (clk),
                .rst_n   (rst_n),
                .src     (irq_in[g*GRP_W +: GRP_W]),
                .set_hit (set_wr && hit_q),
                .clr_hit (clr_wr && hit_q),
                .wbyte   (bus_wdata[LANE*GRP_W +: GRP_W]),
                .pend_o  (pend_flat[g*GRP_W +: GRP_W]),
                .mask_o  (mask_flat[g*GRP_W +: GRP_W]),
                .irq_o   (grp_irq[g])
            );
        end
        for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
            assign raw_q[q] = pend_flat[q*WORD_W +: WORD_W];
            assign msk_q[q] = pend_flat[q*WORD_W +: WORD_W] & mask_flat[q*WORD_W +: WORD_W];
        end
    endgenerate

    combiner_enstore #(.NUM_QUADS(NUM_QUADS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_legal),
        .wq    (quad),
        .wsel  (slot == SLOT_CLR_EN),
        .wdata (bus_wdata),
        .rq    (quad),
        .rsel  (slot == SLOT_CLR_EN),
        .rdata (store_word)
    );

    always_comb begin
        irq_pad                 = '0;
        irq_pad[NUM_GROUPS-1:0] = grp_irq;
    end

    always_comb begin
        rd_word = '0;
        unique case (region)
            REGION_QUAD: begin
                unique case (slot)
                    SLOT_SET_EN, SLOT_CLR_EN: rd_word = store_word;
                    SLOT_RAW:                 rd_word = raw_q[quad];
                    SLOT_MASKED:              rd_word = msk_q[quad];
                endcase
            end
            REGION_SUMMARY: rd_word = sum_word ? irq_pad[WORD_W +: WORD_W] : irq_pad[0 +: WORD_W];
            default:        rd_word = '0;
        endcase
    end

    // Access state: next-state logic
    always_comb begin
        if (bus_wr)
            acc_d = wr_legal ? ACC_IDLE : ACC_WERR;
        else if (bus_rd)
            acc_d = ACC_RDATA;
        else
            acc_d = ACC_IDLE;
    end

    // Access state: state register and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= ACC_IDLE;
            rdata_q <= '0;
        end else begin
            acc_q   <= acc_d;
            rdata_q <= (acc_d == ACC_RDATA) ? rd_word : '0;
        end
    end

    // Access state: outputs
    always_comb begin
        bus_rvalid = 1'b0;
        bus_err    = 1'b0;
        unique case (acc_q)
            ACC_IDLE:  ;
            ACC_RDATA: bus_rvalid = 1'b1;
            ACC_WERR:  bus_err    = 1'b1;
            default:   ;
        endcase
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/combiner_checker.sv
module combiner_checker
    import combiner_pkg::*;
#(
    parameter int NUM_GROUPS = 64,
    parameter bit EXTERNAL   = 1'b0,
    parameter int EXT_GROUPS = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_GROUPS*GRP_W-1:0] irq_in,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic                        bus_rvalid,
    input logic                        bus_err,
    input logic [NUM_GROUPS-1:0]       grp_irq,
    input logic [NUM_GROUPS*GRP_W-1:0] pend_flat,
    input logic [NUM_GROUPS*GRP_W-1:0] mask_flat
);
    logic [NUM_GROUPS*GRP_W-1:0] accept;
    logic [NUM_GROUPS-1:0]       masked_any;
    logic                        past_ok;

    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            accept[g*GRP_W +: GRP_W] = (!EXTERNAL || g < EXT_GROUPS) ? '1 : '0;
            masked_any[g] = |(pend_flat[g*GRP_W +: GRP_W] & mask_flat[g*GRP_W +: GRP_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_PEND_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (pend_flat == ($past(irq_in) & accept)));                        // R1

    AST_OUT_ONE_CLOCK_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (grp_irq == $past(masked_any)));                                 // R2

    AST_MASK_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !bus_wr) |=> $stable(mask_flat));                                // R3

    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && bus_err) |-> $past(bus_wr));                                     // R8

    AST_EXT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_flat & ~accept) == '0);                                                // R10

    AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && bus_rvalid) |-> ($past(bus_rd) && !$past(bus_wr)));              // R11

    AST_NO_DUAL_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rvalid && bus_err));                                                   // R11
endmodule

bind grp_irq_combiner combiner_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .EXTERNAL   (EXTERNAL),
    .EXT_GROUPS (EXT_GROUPS)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .bus_err    (bus_err),
    .grp_irq    (grp_irq),
    .pend_flat  (pend_flat),
    .mask_flat  (mask_flat)
);

// File: tb/test_grp_irq_combiner.sv
module test_grp_irq_combiner;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [511:0] src = '0;
    logic         wr = 1'b0;
    logic         rd = 1'b0;
    logic [10:0]  addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata, rdata_x;
    logic         rvalid, rvalid_x, err, err_x;
    logic [63:0]  irq, irq_x;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    grp_irq_combiner i_grp_irq_combiner (
        .clk(clk), .rst_n(rst_n), .irq_in(src), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .bus_rvalid(rvalid), .bus_err(err), .grp_irq(irq)
    );

    grp_irq_combiner #(.EXTERNAL(1'b1), .EXT_GROUPS(16)) i_grp_irq_combiner_ext (
        .clk(clk), .rst_n(rst_n), .irq_in(src), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_x),
        .bus_rvalid(rvalid_x), .bus_err(err_x), .grp_irq(irq_x)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: actual unexpected response %h expected none", rdata);
            end else begin
                check(tag_q.pop_front(), {32'h0, rdata}, {32'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 outputs", {32'h0, irq[31:0]} | {32'h0, irq[63:32]}, 64'h0);
        check("R9 err", {63'h0, err}, 64'h0);
        check("R9 rvalid", {63'h0, rvalid}, 64'h0);
        bus_read(11'h0C0, 32'h0101_0101, "R7 reset C0");
        bus_read(11'h0D4, 32'h0101_0101, "R7 reset D4");
        bus_read(11'h000, 32'h0, "R7 reset 00");
        bus_read(11'h0C8, 32'h0, "R9 pending zero");
        @(negedge clk);
        check("R11 rvalid single cycle", {63'h0, rvalid}, 64'h0);

        // group 5 bit 3, group 50 bit 7, group 63 bit 7
        src[43] = 1'b1; src[407] = 1'b1; src[511] = 1'b1;
        cycles(2);
        bus_read(11'h018, 32'h0000_0800, "R1 R5 raw quad1");
        bus_read(11'h01C, 32'h0, "R5 masked quad1");
        bus_read(11'h0F8, 32'h8000_0000, "R1 raw quad15");
        check("R2 masked off", irq, 64'h0);

        bus_write(11'h010, 32'h0000_0800);
        check("R2 latency", {63'h0, irq[5]}, 64'h0);
        @(negedge clk);
        check("R3 set enable", {63'h0, irq[5]}, 64'h1);
        bus_read(11'h01C, 32'h0000_0800, "R5 masked quad1");
        bus_read(11'h010, 32'h0000_0800, "R7 stored 10");

        bus_write(11'h0C0, 32'h0080_0000);
        @(negedge clk);
        check("R3 lanes", irq, (64'h1 << 5) | (64'h1 << 50));
        bus_read(11'h400, 32'h0000_0020, "R6 summary low");
        bus_read(11'h404, 32'h0004_0000, "R6 summary high");
        bus_read(11'h0C0, 32'h0080_0000, "R7 stored C0");

        bus_write(11'h0C4, 32'h007F_0000);
        @(negedge clk);
        check("R4 other bits kept", {63'h0, irq[50]}, 64'h1);
        bus_read(11'h0CC, 32'h0080_0000, "R4 masked quad12");

        bus_write(11'h014, 32'h0000_0800);
        @(negedge clk);
        check("R4 clear enable", {63'h0, irq[5]}, 64'h0);
        bus_read(11'h01C, 32'h0, "R4 masked cleared");
        bus_read(11'h014, 32'h0000_0800, "R7 stored 14");

        @(negedge clk); src[407] = 1'b0;
        @(negedge clk);
        check("R2 drop latency", {63'h0, irq[50]}, 64'h1);
        @(negedge clk);
        check("R2 drop", {63'h0, irq[50]}, 64'h0);
        src[407] = 1'b1;
        cycles(2);
        check("R2 rise", {63'h0, irq[50]}, 64'h1);

        bus_write(11'h018, 32'hFFFF_FFFF);
        check("R8 err raw write", {63'h0, err}, 64'h1);
        @(negedge clk);
        check("R8 err one cycle", {63'h0, err}, 64'h0);
        check("R8 dropped", irq, 64'h1 << 50);
        bus_write(11'h404, 32'h0);
        check("R8 err summary write", {63'h0, err}, 64'h1);
        bus_read(11'h404, 32'h0004_0000, "R8 summary unchanged");
        bus_write(11'h100, 32'hFFFF_FFFF);
        check("R8 err hole write", {63'h0, err}, 64'h1);
        bus_read(11'h100, 32'h0, "R8 hole reads zero");
        bus_write(11'h000, 32'h0000_00FF);
        check("R8 legal no err", {63'h0, err}, 64'h0);
        @(negedge clk);
        check("R3 group0 no input", {63'h0, irq[0]}, 64'h0);

        @(negedge clk);
        wr = 1'b1; rd = 1'b1; addr = 11'h004; wdata = 32'h0;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        check("R11 write wins", {62'h0, rvalid, err}, 64'h0);
        bus_read(11'h004, 32'h0, "R11 write performed");

        src[2] = 1'b1;
        cycles(2);
        check("R1 group0 bit2", {63'h0, irq[0]}, 64'h1);
        check("R10 ext low group live", {63'h0, irq_x[0]}, 64'h1);
        check("R10 ext high group ignored", {63'h0, irq_x[50]}, 64'h0);
        check("R10 internal high group live", {63'h0, irq[50]}, 64'h1);

        cycles(3);
        check("R11 all reads answered", {32'h0, exp_q.size()}, 64'h0);
        finish_run();
    end
endmodule